// File: doc/BRIEF.md
# Row-by-Row DRAM Refresh Sequencer

This block keeps one DRAM bank's contents alive by refreshing its rows one at a time, spread evenly over the retention window. A free-running interval timer is sized from the clock frequency, the window length and the number of rows. Each time the timer expires, the block owes the bank one row refresh. It raises a request towards the bank controller and holds it until the controller grants the slot.

Once granted, the block drives a short command sequence for the current row. If the bank has a row open, that row is closed first. All bitlines are then precharged, the target row is activated, and it is held in the restore phase so that the sense amplifiers can rewrite full charge into every cell. Finally the row is closed again, so the bank is left idle with no open row. A one-cycle done pulse marks the end of each row. The row index then steps to the next row and wraps after the last one, so every row is visited once per window.

Refresh slots that expire while the controller is busy are counted rather than lost. Once the controller grants, the owed rows are worked off back to back.

Top module: `refresh_seq`

## Requirements
- R1: The refresh interval is floor(CLK_HZ * WINDOW_NS / (10^9 * 2^ROW_BITS)) clock cycles, with a minimum of 1. When every request is granted at once, the request rises exactly once per interval.
- R2: Once raised, the request stays high until it is granted. Intervals that expire before a grant are remembered. After each finished row, a remaining debt raises the request again in the very next cycle.
- R3: A granted refresh drives `cmd` through a fixed order. CLOSE (code 1) comes first, only if `bank_open` was high in the grant cycle. Then come PRECHARGE (code 2) for one cycle, ACTIVATE (code 3) for one cycle, RESTORE (code 4) for RESTORE_CYC cycles, and a final CLOSE (code 1) for one cycle. At all other times `cmd` is NOP (code 0).
- R4: `row` holds the index of the row being refreshed for the whole sequence. The index increases by one after each finished row.
- R5: After row 2^ROW_BITS-1 has been refreshed, the next row refreshed is row 0.
- R6: `done` is high for exactly one cycle per refreshed row, in the same cycle as the final CLOSE.
- R7: A grant while the request is low has no effect: `cmd` stays NOP and no row is consumed.
- R8: After reset, `cmd` is NOP, `req` and `done` are low and `row` is 0.
- R9: `req` is low whenever a command other than NOP is being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt | input | 1 | Grant from the bank controller, taken when `req` is high |
| bank_open | input | 1 | Bank currently has a row open, sampled with the grant |
| req | output | 1 | Refresh slot requested |
| cmd | output | 3 | Command to the bank: 0 NOP, 1 CLOSE, 2 PRECHARGE, 3 ACTIVATE, 4 RESTORE |
| row | output | ROW_BITS | Row index being refreshed |
| done | output | 1 | One-cycle pulse at the end of each row |

## Verification
The bench uses a bank of 8 rows and a 20-cycle interval, and refreshes more than a full pass so the row index wraps. A counter that skips the wrap would refresh a row outside the bank or stall at the top row. Grants are given both with and without an open row. A design that always or never issues the leading CLOSE would show the wrong first command. The grant is also withheld across several intervals: a block that drops its request, or forgets owed slots, would fail to raise the request in the cycle after each owed row finishes. Grants given while no request is pending must leave the command NOP and the row index unchanged.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_CLOSE   = 3'd1,
        CMD_PRE     = 3'd2,
        CMD_ACT     = 3'd3,
        CMD_RESTORE = 3'd4
    } bank_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLOSE_OLD,
        ST_PRECHARGE,
        ST_ACTIVATE,
        ST_RESTORE,
        ST_CLOSE_NEW
    } seq_state_e;

    // Cycles between row refreshes; never less than one.
    function automatic int unsigned row_interval(
        input longint unsigned clk_hz,
        input longint unsigned window_ns,
        input int unsigned     row_bits
    );
        longint unsigned rows;
        longint unsigned raw;
        rows = 64'd1 << row_bits;
        raw  = (clk_hz * window_ns) / (64'd1_000_000_000 * rows);
        if (raw < 64'd1) begin
            return 1;
        end
        return int'(raw);
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int unsigned INTERVAL = 97,
    parameter int unsigned OWED_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    output logic pending_o
);
    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int unsigned OW = $clog2(OWED_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [OW-1:0] owed;
    } timer_t;

    timer_t st_q, st_d;
    logic   tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == CW'(INTERVAL - 1));
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (tick && !take_i) begin
            if (st_q.owed != OW'(OWED_MAX)) begin
                st_d.owed = st_q.owed + 1'b1;
            end
        end else if (!tick && take_i) begin
            st_d.owed = st_q.owed - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = (st_q.owed != '0);

    AST_TAKE_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pending_o); // R2

    AST_DEBT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !take_i) |=> pending_o); // R2

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int unsigned ROW_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance_i,
    output logic [ROW_BITS-1:0] row_o
);
    typedef struct packed {
        logic [ROW_BITS-1:0] row;
    } rowc_t;

    rowc_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (advance_i) begin
            st_d.row = st_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o = st_q.row;

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(row_o)); // R4

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && (row_o == {ROW_BITS{1'b1}})) |=> (row_o == '0)); // R5

endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
    import refresh_pkg::*;
#(
    parameter int unsigned RESTORE_CYC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pending_i,
    input  logic      gnt_i,
    input  logic      bank_open_i,
    output logic      req_o,
    output logic      take_o,
    output bank_cmd_e cmd_o,
    output logic      done_o
);
    localparam int unsigned RW = $clog2(RESTORE_CYC + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [RW-1:0] hold;
    } fsm_t;

    fsm_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        req_o  = (st_q.state == ST_IDLE) && pending_i;
        take_o = req_o && gnt_i;
        cmd_o  = CMD_NOP;
        done_o = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (take_o) begin
                    st_d.state = bank_open_i ? ST_CLOSE_OLD : ST_PRECHARGE;
                end
            end
            ST_CLOSE_OLD: begin
                cmd_o      = CMD_CLOSE;
                st_d.state = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                cmd_o      = CMD_PRE;
                st_d.state = ST_ACTIVATE;
            end
            ST_ACTIVATE: begin
                cmd_o      = CMD_ACT;
                st_d.state = ST_RESTORE;
                st_d.hold  = RW'(RESTORE_CYC - 1);
            end
            ST_RESTORE: begin
                cmd_o = CMD_RESTORE;
                if (st_q.hold == '0) begin
                    st_d.state = ST_CLOSE_NEW;
                end else begin
                    st_d.hold = st_q.hold - 1'b1;
                end
            end
            ST_CLOSE_NEW: begin
                cmd_o      = CMD_CLOSE;
                done_o     = 1'b1;
                st_d.state = ST_IDLE;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT) |-> ($past(cmd_o) == CMD_PRE)); // R3

    AST_RESTORE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_RESTORE) && ($past(cmd_o) != CMD_RESTORE)) |-> ($past(cmd_o) == CMD_ACT)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != CMD_NOP) |-> !req_o); // R9

    AST_REQ_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i) |=> req_o); // R2

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import refresh_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 100_000_000,
    parameter longint unsigned WINDOW_NS   = 64_000_000,
    parameter int unsigned     ROW_BITS    = 16,
    parameter int unsigned     RESTORE_CYC = 4,
    parameter int unsigned     OWED_MAX    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gnt,
    input  logic                bank_open,
    output logic                req,
    output logic [2:0]          cmd,
    output logic [ROW_BITS-1:0] row,
    output logic                done
);
    localparam int unsigned INTERVAL = row_interval(CLK_HZ, WINDOW_NS, ROW_BITS);

    logic      pending;
    logic      take;
    bank_cmd_e cmd_e;

    refresh_timer #(
        .INTERVAL (INTERVAL),
        .OWED_MAX (OWED_MAX)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .pending_o (pending)
    );

    refresh_fsm #(
        .RESTORE_CYC (RESTORE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_i   (pending),
        .gnt_i       (gnt),
        .bank_open_i (bank_open),
        .req_o       (req),
        .take_o      (take),
        .cmd_o       (cmd_e),
        .done_o      (done)
    );

    refresh_row_ctr #(
        .ROW_BITS (ROW_BITS)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (done),
        .row_o     (row)
    );

    assign cmd = cmd_e;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (row == ROW_BITS'($past(row) + 1'b1))); // R4

    AST_ROW_STABLE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd != 3'd0) && ($past(cmd) != 3'd0)) |-> $stable(row)); // R4

    AST_GNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == 3'd0) && !req) |=> (cmd == 3'd0)); // R7

endmodule

// File: tb/tb_refresh_seq.sv
module tb_refresh_seq;
    localparam int RB    = 3;
    localparam int NROWS = 1 << RB;
    localparam int RC    = 3;
    localparam int IVL   = 20; // 100 MHz * 1600 ns / 8 rows

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gnt = 1'b0;
    logic          bank_open = 1'b0;
    logic          req;
    logic [2:0]    cmd;
    logic [RB-1:0] row;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    refresh_seq #(
        .CLK_HZ      (100_000_000),
        .WINDOW_NS   (1600),
        .ROW_BITS    (RB),
        .RESTORE_CYC (RC),
        .OWED_MAX    (7)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt),
        .bank_open (bank_open),
        .req       (req),
        .cmd       (cmd),
        .row       (row),
        .done      (done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Grant at the current negedge (req high) and follow the whole sequence.
    task automatic serve_row(input bit open, input int exp_row);
        int n;
        int ec;
        n = (open ? 1 : 0) + 3 + RC;
        gnt       = 1'b1;
        bank_open = open;
        @(negedge clk);
        gnt       = 1'b0;
        bank_open = 1'b0;
        for (int i = 0; i < n; i++) begin
            int j;
            j = open ? i : i + 1;
            if (j == 0)            ec = 1;
            else if (j == 1)       ec = 2;
            else if (j == 2)       ec = 3;
            else if (j < 3 + RC)   ec = 4;
            else                   ec = 1;
            chk("R3 cmd order", int'(cmd), ec);
            chk("R4 row held", int'(row), exp_row);
            chk("R9 req low while busy", int'(req), 0);
            chk("R6 done position", int'(done), (i == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R3 NOP after sequence", int'(cmd), 0);
        chk("R6 done one cycle", int'(done), 0);
    endtask

    initial begin
        int last_rise;
        int k;
        repeat (3) @(negedge clk);
        chk("R8 reset cmd", int'(cmd), 0);
        chk("R8 reset req", int'(req), 0);
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset row", int'(row), 0);
        rst_n = 1'b1;

        // R7: grants while no request is pending are ignored.
        gnt = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 stray grant cmd", int'(cmd), 0);
            chk("R7 stray grant row", int'(row), 0);
        end
        gnt = 1'b0;

        // R1, R4, R5: immediate grants for more than one pass over the bank.
        k = 0;
        last_rise = -1;
        for (int r = 0; r < NROWS + 5; r++) begin
            while (!req) @(negedge clk);
            if (last_rise >= 0) chk("R1 interval", cyc - last_rise, IVL);
            last_rise = cyc;
            serve_row((k % 3) == 0, k % NROWS);
            if (k == NROWS) chk("R5 wrap to row 0", 0, 0);
            k++;
        end

        // R2: withhold the grant across several intervals.
        while (!req) @(negedge clk);
        for (int i = 0; i < 50; i++) begin
            chk("R2 req held", int'(req), 1);
            @(negedge clk);
        end
        for (int r = 0; r < 3; r++) begin
            chk("R2 owed request immediate", int'(req), 1);
            serve_row(r == 1, k % NROWS);
            k++;
        end
        // Work off any remaining debt and confirm the idle state.
        while (req) begin
            serve_row(1'b0, k % NROWS);
            k++;
        end
        chk("R4 row after backlog", int'(row), k % NROWS);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule